// File: doc/BRIEF.md
# Iterative Booth Multiply and Multiply-Accumulate Unit

This unit multiplies two 32-bit operands, the multiplicand `rm` and the multiplier `rs`, and can add an accumulator to the product. It works through the multiplier a few bits per cycle using Booth recoding. Each cycle takes one Booth digit and adds one partial product into a 64-bit running sum. The unit stops as soon as the multiplier bits still to be consumed can no longer change the sum, so the number of cycles depends on the data. The parameter `ENH` picks one of two variants. The basic variant uses 2 bits per cycle and stops only on an all-zero remainder. The enhanced variant uses 8 bits per cycle and stops on an all-zero or an all-one remainder.

Operands are captured when `start` is accepted. In the short form the result is the low 32 bits of `rm*rs`, or of `rm*rs + acc_lo`. In the long form the result is the full 64-bit product, optionally added to `{acc_hi, acc_lo}`. The long form treats the operands as signed or unsigned according to `is_signed`. An unsigned multiplier is zero-extended before it is recoded. The unit also reports a negative flag and a zero flag for the result.

The controller has four states. IDLE goes to SETUP on `start`. SETUP always goes to STEP. STEP stays in STEP until the termination test holds, then goes to FINISH. FINISH goes to SETUP if `start` is high and to IDLE otherwise.

Top module: `booth_mul_unit`

## Requirements
- R1: In the short form (`long_mode`=0), `res_lo` = low 32 bits of `rm*rs` (+`acc_lo` when `accumulate`=1) and `res_hi` = 0.
- R2: In the long signed form (`long_mode`=1, `is_signed`=1), `{res_hi,res_lo}` = two's-complement `rm*rs` (+`{acc_hi,acc_lo}` when `accumulate`=1), modulo 2^64.
- R3: In the long unsigned form (`long_mode`=1, `is_signed`=0), both operands are taken as unsigned, and `{res_hi,res_lo}` = `rm*rs` (+ accumulator), modulo 2^64.
- R4: Basic variant (`ENH`=0): `busy` is high for 1+G cycles. G is the smallest group count ≥1 such that the extended multiplier bits from position 2G-1 upward are all zero, or, when the multiplier is sign-extended, 2G ≥ 32. For example, `rs`=18 gives 4 cycles and `rs`=-1 gives 17.
- R5: Enhanced variant (`ENH`=1): the same rule applies with 8-bit groups, and an all-one remainder from bit 8G-1 upward also ends the run. Short and signed runs therefore take at most 5 cycles, and `rs`=18 and `rs`=-1 each take 2. In the long unsigned form the zero extension means an all-one remainder never occurs.
- R6: `flag_n` is bit 63 of the result in the long form and bit 31 in the short form. `flag_z` is 1 exactly when the whole result (64 or 32 bits) is zero.
- R7: `done` is high for exactly one cycle, the cycle right after the last `busy` cycle, and `busy` is low in that cycle. The results and flags change only as `done` rises, and they hold their values afterwards.
- R8: A `start` while `busy` is high is ignored. The running operation keeps its operands, its result and its cycle count.
- R9: A `start` in the `done` cycle is accepted, and the next operation begins at once.
- R10: After reset, `busy`, `done`, `res_lo`, `res_hi`, `flag_n` and `flag_z` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation |
| rm | input | 32 | Multiplicand |
| rs | input | 32 | Multiplier (Booth recoded) |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word (long form only) |
| accumulate | input | 1 | Add the accumulator to the product |
| is_signed | input | 1 | Signed operands in the long form |
| long_mode | input | 1 | 1: 64-bit result; 0: 32-bit result |
| busy | output | 1 | Operation in progress (SETUP or STEP) |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word (0 in the short form) |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
Completion and acceptance of a new request can fall in the same cycle. The bench provokes this by raising `start` on the very cycle it sees `done`. It then checks that the second operation produces its own correct product, with the cycle count predicted from its multiplier, and that the first result was reported intact. The bench also raises `start` in the middle of a run with different operands. It judges that case by the unchanged result and latency of the run already in progress. Both variants are instantiated side by side and receive the same mix of random and directed multipliers, including small positive values, small negative values and all-ones patterns.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STEP   = 2'd2,
        ST_FINISH = 2'd3
    } mul_state_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode #(
    parameter int K = 2
) (
    input  logic [K-1:0]        grp,
    input  logic                cin,
    output logic signed [K:0]   digit
);
    // digit = signed value of the group plus the carry from the group below
    always_comb begin
        digit = $signed({grp[K-1], grp}) + $signed({{K{1'b0}}, cin});
    end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen #(
    parameter int AW = 64,
    parameter int K  = 2
) (
    input  logic [AW-1:0]       mcand,
    input  logic signed [K:0]   digit,
    output logic [AW-1:0]       pp
);
    generate
        if (K == 2) begin : g_mux
            always_comb begin
                unique case (digit)
                    3'sd1:   pp = mcand;
                    3'sd2:   pp = mcand << 1;
                    -3'sd1:  pp = -mcand;
                    -3'sd2:  pp = -(mcand << 1);
                    default: pp = '0;
                endcase
            end
        end else begin : g_mult
            logic [AW-1:0] dext;
            always_comb begin
                dext = {{(AW-K-1){digit[K]}}, digit};
                pp   = mcand * dext;
            end
        end
    endgenerate
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       term,
    output mul_state_t state_o,
    output logic       busy,
    output logic       done,
    output logic       load,
    output logic       step
);
    mul_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STEP;
            ST_STEP:   if (term) state_d = ST_FINISH;
            ST_FINISH: state_d = start ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == ST_SETUP) || (state_q == ST_STEP);
        done = (state_q == ST_FINISH);
        load = start && ((state_q == ST_IDLE) || (state_q == ST_FINISH));
        step = (state_q == ST_STEP);
    end

    assign state_o = state_q;

    // R8: a request during a run never restarts setup
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != ST_SETUP));

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: request in the done cycle starts the next run
    p_b2b_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (state_q == ST_SETUP));
endmodule

// File: rtl/booth_mul_unit.sv
module booth_mul_unit
    import booth_pkg::*;
#(
    parameter int W   = 32,
    parameter bit ENH = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   rm,
    input  logic [31:0]   rs,
    input  logic [31:0]   acc_lo,
    input  logic [31:0]   acc_hi,
    input  logic          accumulate,
    input  logic          is_signed,
    input  logic          long_mode,
    output logic          busy,
    output logic          done,
    output logic [31:0]   res_lo,
    output logic [31:0]   res_hi,
    output logic          flag_n,
    output logic          flag_z
);
    localparam int K      = ENH ? 8 : 2;
    localparam int GROUPS = (W + K) / K;
    localparam int RSW    = GROUPS * K;
    localparam int AW     = 2 * W;
    localparam int CW     = $clog2(GROUPS + 1);
    localparam int TOPG   = W / K - 1;
    localparam int TW     = RSW - K + 1;

    mul_state_t            state;
    logic                  load, step, term;
    logic                  sx_in;
    logic [RSW-1:0]        rs_ext, rs_sh;
    logic                  carry_q;
    logic [AW-1:0]         mcand_ext, mcand_q, acc_init, acc_q, acc_nxt, pp;
    logic [CW-1:0]         cnt_q;
    logic                  long_q;
    logic signed [K:0]     digit;
    logic [TW-1:0]         tail;
    logic                  tail_zero, tail_ones, at_top, ones_stop;

    booth_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .term    (term),
        .state_o (state),
        .busy    (busy),
        .done    (done),
        .load    (load),
        .step    (step)
    );

    booth_recode #(.K(K)) u_rec (
        .grp   (rs_sh[K-1:0]),
        .cin   (carry_q),
        .digit (digit)
    );

    booth_ppgen #(.AW(AW), .K(K)) u_pp (
        .mcand (mcand_q),
        .digit (digit),
        .pp    (pp)
    );

    // operand extension: zero only for the long unsigned form
    always_comb begin
        sx_in     = ~(long_mode & ~is_signed);
        rs_ext    = {{(RSW-W){sx_in & rs[W-1]}}, rs};
        mcand_ext = {{(AW-W){sx_in & rm[W-1]}}, rm};
        if (!accumulate)    acc_init = '0;
        else if (long_mode) acc_init = {acc_hi, acc_lo};
        else                acc_init = {{W{1'b0}}, acc_lo};
    end

    // early termination on the unconsumed multiplier remainder
    always_comb begin
        acc_nxt   = acc_q + pp;
        tail      = rs_sh[RSW-1:K-1];
        tail_zero = ~|tail;
        tail_ones = &tail;
        at_top    = (cnt_q >= CW'(TOPG));
    end

    generate
        if (ENH) begin : g_ones_any
            assign ones_stop = tail_ones;
        end else begin : g_ones_top
            assign ones_stop = tail_ones & at_top;
        end
    endgenerate

    assign term = tail_zero | ones_stop | (cnt_q == CW'(GROUPS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_sh   <= '0;
            carry_q <= 1'b0;
            mcand_q <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
            long_q  <= 1'b0;
            res_lo  <= '0;
            res_hi  <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
        end else if (load) begin
            rs_sh   <= rs_ext;
            carry_q <= 1'b0;
            mcand_q <= mcand_ext;
            acc_q   <= acc_init;
            cnt_q   <= '0;
            long_q  <= long_mode;
        end else if (step) begin
            acc_q   <= acc_nxt;
            mcand_q <= mcand_q << K;
            rs_sh   <= {{K{rs_sh[RSW-1]}}, rs_sh[RSW-1:K]};
            carry_q <= rs_sh[K-1];
            cnt_q   <= cnt_q + 1'b1;
            if (term) begin
                res_lo <= acc_nxt[W-1:0];
                res_hi <= long_q ? acc_nxt[AW-1:W] : '0;
                flag_n <= long_q ? acc_nxt[AW-1] : acc_nxt[W-1];
                flag_z <= long_q ? ~|acc_nxt : ~|acc_nxt[W-1:0];
            end
        end
    end

    // checker: length of the current busy run
    logic [7:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 8'd1;
        else           run_q <= '0;
    end

    // R4 / R5: a run never exceeds setup plus every group
    p_lat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= 8'(GROUPS)));

    // R7: outputs move only together with done
    p_res_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_hi, res_lo, flag_n, flag_z}) |-> done);

    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6: flags agree with the reported words
    p_flag_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_n == (long_q ? res_hi[W-1] : res_lo[W-1])));

    p_flag_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (long_q ? ({res_hi, res_lo} == '0) : (res_lo == '0))));

    // R1: short form clears the high word
    p_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !long_q) |-> (res_hi == '0));
endmodule

// File: tb/tb_booth_mul_unit.sv
module tb_booth_mul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] rm = '0, rs = '0, acc_lo = '0, acc_hi = '0;
    logic        accumulate = 1'b0, is_signed = 1'b0, long_mode = 1'b0;

    logic        b_busy, b_done, b_n, b_z;
    logic [31:0] b_lo, b_hi;
    logic        e_busy, e_done, e_n, e_z;
    logic [31:0] e_lo, e_hi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    booth_mul_unit #(.ENH(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rm(rm), .rs(rs),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .accumulate(accumulate),
        .is_signed(is_signed), .long_mode(long_mode),
        .busy(b_busy), .done(b_done), .res_lo(b_lo), .res_hi(b_hi),
        .flag_n(b_n), .flag_z(b_z));

    booth_mul_unit #(.ENH(1'b1)) dut_enh (
        .clk(clk), .rst_n(rst_n), .start(start), .rm(rm), .rs(rs),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .accumulate(accumulate),
        .is_signed(is_signed), .long_mode(long_mode),
        .busy(e_busy), .done(e_done), .res_lo(e_lo), .res_hi(e_hi),
        .flag_n(e_n), .flag_z(e_z));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_res(input logic [31:0] a, input logic [31:0] b,
            input logic [31:0] lo, input logic [31:0] hi, input bit accum, input bit sg, input bit lng);
        logic [63:0] ax, bx, acc, r;
        bit sx;
        sx  = !(lng && !sg);
        ax  = sx ? {{32{a[31]}}, a} : {32'b0, a};
        bx  = sx ? {{32{b[31]}}, b} : {32'b0, b};
        acc = !accum ? 64'b0 : (lng ? {hi, lo} : {32'b0, lo});
        r   = ax * bx + acc;
        if (!lng) r = {32'b0, r[31:0]};
        return r;
    endfunction

    function automatic int exp_lat(input logic [31:0] r, input bit sx, input int k, input bit enh);
        logic [63:0] e;
        e = sx ? {{32{r[31]}}, r} : {32'b0, r};
        for (int g = 1; g <= 20; g++) begin
            int pos;
            logic [63:0] up, ones_ref;
            pos      = k * g - 1;
            up       = e >> pos;
            ones_ref = {64{1'b1}} >> pos;
            if (up == 64'b0) return 1 + g;
            if (up == ones_ref && (enh || k * g >= 32)) return 1 + g;
        end
        return 99;
    endfunction

    task automatic judge(input string req, input logic [31:0] a, input logic [31:0] b,
            input logic [31:0] lo, input logic [31:0] hi, input bit accum, input bit sg, input bit lng,
            input bit enh, input logic [31:0] rlo, input logic [31:0] rhi, input bit fn, input bit fz, input int nb);
        logic [63:0] x;
        bit sx;
        int el;
        x  = exp_res(a, b, lo, hi, accum, sg, lng);
        sx = !(lng && !sg);
        el = exp_lat(b, sx, enh ? 8 : 2, enh);
        check(rlo == x[31:0], {req, " res_lo"}, {32'b0, rlo}, {32'b0, x[31:0]});
        check(rhi == x[63:32], {req, " res_hi (R1/R2/R3)"}, {32'b0, rhi}, {32'b0, x[63:32]});
        check(fn == (lng ? x[63] : x[31]), {req, " R6 flag_n"}, {63'b0, fn}, {63'b0, (lng ? x[63] : x[31])});
        check(fz == (x == 64'b0), {req, " R6 flag_z"}, {63'b0, fz}, {63'b0, (x == 64'b0)});
        check(nb == el, enh ? {req, " R5 latency"} : {req, " R4 latency"}, 64'(nb), 64'(el));
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] lo,
            input logic [31:0] hi, input bit accum, input bit sg, input bit lng, input bit inject, input string req);
        int nb, ne;
        bit fb, fe;
        logic [31:0] blo, bhi, elo, ehi;
        bit bn, bz, en, ez;
        @(negedge clk);
        rm = a; rs = b; acc_lo = lo; acc_hi = hi;
        accumulate = accum; is_signed = sg; long_mode = lng; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0; ne = 0; fb = 0; fe = 0;
        blo = '0; bhi = '0; elo = '0; ehi = '0; bn = 0; bz = 0; en = 0; ez = 0;
        for (int t = 0; t < 40; t++) begin
            if (b_busy) nb++;
            if (e_busy) ne++;
            if (b_done) begin
                check(!fb, {req, " R7 second done basic"}, 64'(1), 64'(0));
                fb = 1; blo = b_lo; bhi = b_hi; bn = b_n; bz = b_z;
            end
            if (e_done) begin
                check(!fe, {req, " R7 second done enh"}, 64'(1), 64'(0));
                fe = 1; elo = e_lo; ehi = e_hi; en = e_n; ez = e_z;
            end
            if (fb && fe) break;
            if (inject && t == 1) begin
                // R8: mid-run request with other operands
                start = 1'b1; rm = ~a; rs = b ^ 32'h5a5a0f0f; accumulate = ~accum;
            end
            if (inject && t == 2) start = 1'b0;
            @(negedge clk);
        end
        check(fb && fe, {req, " R7 done seen"}, {62'b0, fb, fe}, 64'd3);
        judge({req, " basic"}, a, b, lo, hi, accum, sg, lng, 1'b0, blo, bhi, bn, bz, nb);
        judge({req, " enh"},   a, b, lo, hi, accum, sg, lng, 1'b1, elo, ehi, en, ez, ne);
        start = 1'b0;
    endtask

    function automatic logic [31:0] pick_rs(input int sel);
        case (sel)
            0:       return $urandom % 64;
            1:       return -($urandom % 64);
            2:       return $urandom;
            default: return $urandom >> ($urandom % 32);
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        logic [31:0] hlo, hhi;
        int nb;
        bit got;
        seed_init = $urandom(32'd6011);
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!b_busy && !b_done && !e_busy && !e_done, "R10 busy/done", {60'b0, b_busy, b_done, e_busy, e_done}, 64'b0);
        check(b_lo == 0 && b_hi == 0 && e_lo == 0 && e_hi == 0, "R10 results", {b_lo, e_hi}, 64'b0);
        check(!b_n && !b_z && !e_n && !e_z, "R10 flags", {60'b0, b_n, b_z, e_n, e_z}, 64'b0);
        rst_n = 1'b1;

        // directed corner cases
        run_op(32'd7, 32'd18, 0, 0, 0, 1, 0, 0, "R4 R5 rs=18");
        run_op(32'd7, 32'hffffffff, 0, 0, 0, 1, 0, 0, "R4 R5 rs=-1");
        run_op(32'd0, 32'd0, 0, 0, 0, 1, 0, 0, "R6 zero");
        run_op(32'hffffffff, 32'hffffffff, 0, 0, 0, 0, 1, 0, "R3 unsigned max");
        run_op(32'h80000000, 32'h80000000, 0, 0, 0, 1, 1, 0, "R2 signed min");
        run_op(32'h12345678, 32'hfffffff0, 32'h0000_0001, 32'hffff_ffff, 1, 1, 1, 0, "R2 mla long");
        run_op(32'd5, 32'd3, 32'hfffffff1, 0, 1, 1, 0, 0, "R1 R6 mla wraps to zero");
        run_op(32'h0000_0100, 32'hffff_ff00, 32'h0, 32'h0, 0, 0, 1, 0, "R3 zero-extended ones");
        run_op(32'hdeadbeef, 32'h00000ace, 32'h1111, 32'h2222, 1, 1, 0, 1, "R8 ignored start");

        // R7: results held after done
        hlo = b_lo; hhi = b_hi;
        repeat (3) @(negedge clk);
        check(b_lo == hlo && b_hi == hhi && !b_done, "R7 hold", {b_hi, b_lo}, {hhi, hlo});

        // R9: start accepted in the done cycle (basic variant)
        @(negedge clk);
        rm = 32'd3; rs = 32'hffffffff; accumulate = 0; is_signed = 1; long_mode = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        for (int t = 0; t < 40 && !got; t++) begin
            if (b_done) got = 1;
            else @(negedge clk);
        end
        check(b_lo == 32'hfffffffd, "R9 first result", {32'b0, b_lo}, 64'hfffffffd);
        rm = 32'd9; rs = 32'd18; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0; got = 0;
        for (int t = 0; t < 40 && !got; t++) begin
            if (b_busy) nb++;
            if (b_done) got = 1;
            else @(negedge clk);
        end
        check(got && b_lo == 32'd162, "R9 back-to-back result", {32'b0, b_lo}, 64'd162);
        check(nb == 4, "R9 back-to-back latency", 64'(nb), 64'd4);
        repeat (25) @(negedge clk);

        // constrained random mix
        for (int i = 0; i < 160; i++) begin
            logic [31:0] a, b, lo, hi;
            bit accum, sg, lng;
            a  = ($urandom % 3 == 0) ? pick_rs($urandom % 4) : $urandom;
            b  = pick_rs($urandom % 4);
            lo = $urandom; hi = $urandom;
            accum = $urandom % 2; sg = $urandom % 2; lng = $urandom % 2;
            run_op(a, b, lo, hi, accum, sg, lng, (i % 16) == 5,
                   lng ? (sg ? "R2 random" : "R3 random") : "R1 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule